// File: doc/BRIEF.md
# Byte-Lane Bus Width Narrower

This block connects a 32-bit memory-mapped master to a slave whose data path is only 8 or 16 bits wide, with the width set by a parameter. Each master access is broken into narrow slave cycles. Only the narrow words that hold at least one enabled byte lane get a cycle, so a byte access costs one cycle. A halfword costs one or two cycles and a full word costs two or four, depending on the slave width. A narrow word whose lanes are all disabled is skipped and never issued.

Narrow cycles go out from the lowest enabled narrow word upward. The narrow address is the master word address times the number of narrow words per 32-bit word, plus the index of the narrow word. Read data is gathered lane by lane into a 32-bit holding register. Lanes that are not read return zero. The master is held with its wait signal until the last narrow cycle has finished, and the assembled word is presented in the cycle that the wait drops. The slave's own wait signal freezes the current narrow cycle.

Top module: `bus_narrower`

## Requirements
- R1: With an 8-bit slave (four narrow words, one lane each), an access issues one slave cycle for every master byte enable that is set: one for a byte, two for a halfword, four for a word.
- R2: With a 16-bit slave (two narrow words; word 0 takes lanes 1:0, word 1 takes lanes 3:2), an access issues one slave cycle for each half that has at least one enable set.
- R3: The byte enables of each slave cycle equal the master's enables for the lanes of that narrow word, and they are never all zero while a strobe is high.
- R4: The slave byte enables are nonzero only while a read or write strobe is high, and the read and write strobes are never high together.
- R5: The slave address of each cycle is the master word address times the number of narrow words, plus the narrow word index. Cycles are issued in strictly ascending address order.
- R6: On a write, each slave cycle carries the slice of the master write data for its narrow word, so exactly the enabled bytes of the target are updated.
- R7: On a read, each enabled lane of the returned word holds the byte the slave gave for that lane, and every disabled lane reads zero. The word is valid in the cycle that the master wait is low.
- R8: The master wait stays high from acceptance until the last narrow cycle completes. With a slave that never stalls, it is high for exactly as many sampled cycles as there are narrow cycles. While the slave wait is high, the narrow address, enables, data and strobes hold steady.
- R9: Synchronous active-low reset returns the block to idle with both slave strobes low and the returned read word cleared to zero, even in the middle of an access.
- R10: An access with no byte enables set issues no slave cycle, completes after the accept cycle, and returns zero on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | MST_AW | Master word address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables, bit n for bits 8n+7:8n |
| m_rdata | output | 32 | Assembled read word |
| m_wait | output | 1 | Master wait; access finishes on the edge where it is low |
| s_addr | output | MST_AW+log2(32/SLV_W) | Narrow word address |
| s_read | output | 1 | Narrow read strobe |
| s_write | output | 1 | Narrow write strobe |
| s_wdata | output | SLV_W | Narrow write data |
| s_be | output | SLV_W/8 | Narrow byte enables |
| s_rdata | input | SLV_W | Narrow read data |
| s_wait | input | 1 | Slave wait; holds the current narrow cycle |

## Verification
The assertions take two things for granted. First, the master holds address, enables, data and its single strobe steady until it samples the wait low, and it never raises read and write together. Second, the slave answers every strobe eventually. The bench drives the master only through one access task, which sets everything once and releases the strobe only after the completing edge. The slave model's stalls come from a free-running pseudo-random sequence, so they may come and go in any cycle without ever blocking for good. Both widths are swept over all sixteen enable patterns for reads and for writes, with and without stalls.

// File: rtl/bus_narrower_pkg.sv
// Shared types for the bus width narrower.
// Assumes nothing beyond a single clock domain.
package bus_narrower_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } bn_state_t;
endpackage

// File: rtl/bn_lane_need.sv
// Marks each narrow word that holds at least one enabled master byte lane.
// Assumes LPW * NW == 4.
module bn_lane_need #(
    parameter int NW  = 2,
    parameter int LPW = 2
) (
    input  logic [3:0]    be,
    output logic [NW-1:0] need
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        // A narrow word is needed when any of its lanes is enabled.
        assign need[i] = |be[i*LPW +: LPW];
    end
endmodule

// File: rtl/bn_lane_pick.sv
// Picks the lowest pending narrow word and gives its index and one-hot mask.
// Assumes rem may be zero; idx is then zero and onehot is empty.
module bn_lane_pick #(
    parameter int NW   = 2,
    parameter int IDXW = 1
) (
    input  logic [NW-1:0]   rem,
    output logic [IDXW-1:0] idx,
    output logic [NW-1:0]   onehot
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (rem[i]) idx = IDXW'(i);
        end
    end

    // Isolate the lowest set bit.
    assign onehot = rem & (~rem + NW'(1));
endmodule

// File: rtl/bn_read_gather.sv
// Holding register that collects narrow read data into its own byte lanes.
// Assumes clr and cap are never high together; disabled lanes stay zero.
module bn_read_gather #(
    parameter int SLV_W = 16,
    parameter int NW    = 2,
    parameter int LPW   = 2,
    parameter int IDXW  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap,
    input  logic [IDXW-1:0]  idx,
    input  logic [3:0]       be_q,
    input  logic [SLV_W-1:0] s_rdata,
    output logic [31:0]      hold
);
    for (genvar b = 0; b < 4; b++) begin : g_lane
        localparam int OWNER = b / LPW;
        localparam int SUB   = b % LPW;
        logic lane_we;

        // A lane loads when its narrow word completes and the lane is enabled.
        assign lane_we = cap && (idx == IDXW'(OWNER)) && be_q[b];

        // Per-lane storage with reset and clear to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)       hold[b*8 +: 8] <= 8'h00;
            else if (clr)     hold[b*8 +: 8] <= 8'h00;
            else if (lane_we) hold[b*8 +: 8] <= s_rdata[SUB*8 +: 8];
        end
    end
endmodule

// File: rtl/bus_narrower.sv
// Splits 32-bit master accesses into 8- or 16-bit slave cycles, one per
// narrow word that has an enabled lane, lowest first.
// Assumes: the master holds its request stable until m_wait is low and never
// raises read and write together; the slave eventually drops s_wait.
module bus_narrower #(
    parameter int SLV_W  = 16,
    parameter int MST_AW = 8,
    localparam int LPW    = SLV_W / 8,
    localparam int NW     = 32 / SLV_W,
    localparam int IDXW   = $clog2(NW),
    localparam int SLV_AW = MST_AW + IDXW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MST_AW-1:0] m_addr,
    input  logic              m_read,
    input  logic              m_write,
    input  logic [31:0]       m_wdata,
    input  logic [3:0]        m_be,
    output logic [31:0]       m_rdata,
    output logic              m_wait,
    output logic [SLV_AW-1:0] s_addr,
    output logic              s_read,
    output logic              s_write,
    output logic [SLV_W-1:0]  s_wdata,
    output logic [LPW-1:0]    s_be,
    input  logic [SLV_W-1:0]  s_rdata,
    input  logic              s_wait
);
    import bus_narrower_pkg::*;

    bn_state_t         state;
    logic [MST_AW-1:0] addr_q;
    logic [3:0]        be_q;
    logic [31:0]       wdata_q;
    logic              wr_q;
    logic [NW-1:0]     rem_q;
    logic [NW-1:0]     need;
    logic [NW-1:0]     onehot;
    logic [NW-1:0]     rem_next;
    logic [IDXW-1:0]   idx;
    logic              req;
    logic              busy;
    logic              hs;
    logic              accept;

    assign req      = m_read | m_write;
    assign busy     = (state == ST_BUSY);
    assign hs       = busy && !s_wait;
    assign accept   = (state == ST_IDLE) && req;
    assign rem_next = rem_q & ~onehot;

    bn_lane_need #(.NW(NW), .LPW(LPW)) u_need (
        .be   (m_be),
        .need (need)
    );

    bn_lane_pick #(.NW(NW), .IDXW(IDXW)) u_pick (
        .rem    (rem_q),
        .idx    (idx),
        .onehot (onehot)
    );

    bn_read_gather #(.SLV_W(SLV_W), .NW(NW), .LPW(LPW), .IDXW(IDXW)) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .cap     (hs && !wr_q),
        .idx     (idx),
        .be_q    (be_q),
        .s_rdata (s_rdata),
        .hold    (m_rdata)
    );

    // Sequencer: latch the access, walk the pending narrow words, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            rem_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        addr_q  <= m_addr;
                        be_q    <= m_be;
                        wdata_q <= m_wdata;
                        wr_q    <= m_write;
                        rem_q   <= need;
                        state   <= (|need) ? ST_BUSY : ST_DONE;
                    end
                end
                ST_BUSY: begin
                    if (!s_wait) begin
                        rem_q <= rem_next;
                        if (rem_next == '0) state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Narrow-side lane slice for the word being served.
    always_comb begin
        s_be    = '0;
        s_wdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (busy && idx == IDXW'(i)) begin
                s_be    = be_q[i*LPW +: LPW];
                s_wdata = wdata_q[i*SLV_W +: SLV_W];
            end
        end
    end

    assign s_addr  = {addr_q, idx};
    assign s_read  = busy && !wr_q;
    assign s_write = busy && wr_q;
    assign m_wait  = req && (state != ST_DONE);

    // Handshake counter used only by the bound check below.
    logic [IDXW:0] hs_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      hs_cnt <= '0;
        else if (accept) hs_cnt <= '0;
        else if (hs)     hs_cnt <= hs_cnt + 1'b1;
    end

    AST_NO_EMPTY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read || s_write) |-> (s_be != '0)); // R3

    AST_BE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_be != '0) |-> (s_read || s_write)); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_read && s_write)); // R4

    AST_ASCENDING_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && !s_wait) |=> (!(s_read || s_write) || (s_addr > $past(s_addr)))); // R5

    AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_wait) |=> ($stable(s_addr) && $stable(s_be) && $stable(s_wdata)
                                             && $stable(s_read) && $stable(s_write))); // R8

    AST_CYCLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> (hs_cnt < (IDXW+1)'(NW))); // R1

    AST_ZERO_BE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && m_be == 4'h0) |=> (!s_read && !s_write && m_rdata == 32'h0)); // R10

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!s_read && !s_write && m_rdata == 32'h0)); // R9
endmodule

// File: tb/sim_bus_narrower.sv
module sim_bus_narrower;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Shared master stimulus, steered to one instance by sel.
    logic          sel = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [31:0]   m_wdata = '0;
    logic [3:0]    m_be = '0;
    logic          m_rd = 1'b0;
    logic          m_wr = 1'b0;

    // Instance 0: 16-bit slave. Instance 1: 8-bit slave.
    logic [31:0]   rd0, rd1;
    logic          w0, w1;
    logic [AW:0]   s0_addr;
    logic          s0_read, s0_write;
    logic [15:0]   s0_wdata, s0_rdata;
    logic [1:0]    s0_be;
    logic          s0_wait = 1'b0;
    logic [AW+1:0] s1_addr;
    logic          s1_read, s1_write;
    logic [7:0]    s1_wdata, s1_rdata;
    logic [0:0]    s1_be;
    logic          s1_wait = 1'b0;

    bus_narrower #(.SLV_W(16), .MST_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr),
        .m_read(m_rd && !sel), .m_write(m_wr && !sel),
        .m_wdata(m_wdata), .m_be(m_be), .m_rdata(rd0), .m_wait(w0),
        .s_addr(s0_addr), .s_read(s0_read), .s_write(s0_write),
        .s_wdata(s0_wdata), .s_be(s0_be), .s_rdata(s0_rdata), .s_wait(s0_wait));

    bus_narrower #(.SLV_W(8), .MST_AW(AW)) u1 (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr),
        .m_read(m_rd && sel), .m_write(m_wr && sel),
        .m_wdata(m_wdata), .m_be(m_be), .m_rdata(rd1), .m_wait(w1),
        .s_addr(s1_addr), .s_read(s1_read), .s_write(s1_write),
        .s_wdata(s1_wdata), .s_be(s1_be), .s_rdata(s1_rdata), .s_wait(s1_wait));

    // Byte-addressed slave memories: byte address = word address * 4 + lane.
    logic [7:0] mem0 [256];
    logic [7:0] mem1 [256];
    initial for (int k = 0; k < 256; k++) begin
        mem0[k] = 8'((k * 7 + 3) ^ 8'h5A);
        mem1[k] = 8'((k * 7 + 3) ^ 8'h5A);
    end

    assign s0_rdata = {mem0[{s0_addr, 1'b1}], mem0[{s0_addr, 1'b0}]};
    assign s1_rdata = mem1[s1_addr];

    // Slave write ports.
    always @(posedge clk) begin
        if (s0_write && !s0_wait) begin
            if (s0_be[0]) mem0[{s0_addr, 1'b0}] <= s0_wdata[7:0];
            if (s0_be[1]) mem0[{s0_addr, 1'b1}] <= s0_wdata[15:8];
        end
        if (s1_write && !s1_wait && s1_be[0]) mem1[s1_addr] <= s1_wdata;
    end

    // Pseudo-random stalls, changed away from the active edge.
    logic       stall_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        s0_wait <= stall_en && lfsr[0];
        s1_wait <= stall_en && lfsr[2];
    end

    // Handshake logs per instance.
    int         n0 = 0, n1 = 0;
    int         log_addr [2][1024];
    int         log_be   [2][1024];
    always @(posedge clk) begin
        if ((s0_read || s0_write) && !s0_wait) begin
            log_addr[0][n0] <= int'(s0_addr);
            log_be[0][n0]   <= int'(s0_be);
            n0 <= n0 + 1;
        end
        if ((s1_read || s1_write) && !s1_wait) begin
            log_addr[1][n1] <= int'(s1_addr);
            log_be[1][n1]   <= int'(s1_be);
            n1 <= n1 + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int s, input int a);
        return (s != 0) ? mem1[a] : mem0[a];
    endfunction

    // One master access; returns read word, waited cycles and log start index.
    task automatic do_access(input int s, input int a, input logic [3:0] be, input bit wr,
                             input logic [31:0] wd, output logic [31:0] rd,
                             output int waits, output int start);
        @(negedge clk);
        start = (s != 0) ? n1 : n0;
        sel = (s != 0); m_addr = AW'(a); m_be = be; m_wdata = wd;
        m_rd = !wr; m_wr = wr; waits = 0;
        forever begin
            @(negedge clk);
            if (!((s != 0) ? w1 : w0)) break;
            waits++;
            if (waits > 200) break;
        end
        rd = (s != 0) ? rd1 : rd0;
        @(negedge clk);
        m_rd = 1'b0; m_wr = 1'b0;
    endtask

    // Check narrow-cycle count, order, addresses and enables of one access.
    task automatic chk_cycles(input int s, input int a, input logic [3:0] be, input int start);
        int nw  = (s != 0) ? 4 : 2;
        int lpw = (s != 0) ? 1 : 2;
        int k   = start;
        int got = ((s != 0) ? n1 : n0) - start;
        int exp_n = 0;
        for (int i = 0; i < nw; i++) begin
            int sl = (int'(be) >> (i * lpw)) & ((1 << lpw) - 1);
            if (sl != 0) begin
                exp_n++;
                chk("R5 narrow address", log_addr[s][k], a * nw + i);
                chk("R3 narrow enables", log_be[s][k], sl);
                k++;
            end
        end
        if (s != 0) chk("R1 cycle count 8-bit", got, exp_n);
        else        chk("R2 cycle count 16-bit", got, exp_n);
        if (be == 4'h0) chk("R10 no cycle on empty enables", got, 0);
    endtask

    function automatic int narrow_count(input int s, input logic [3:0] be);
        int nw  = (s != 0) ? 4 : 2;
        int lpw = (s != 0) ? 1 : 2;
        int c = 0;
        for (int i = 0; i < nw; i++)
            if (((int'(be) >> (i * lpw)) & ((1 << lpw) - 1)) != 0) c++;
        return c;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp;
        int waits, start;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: idle after reset.
        chk("R9 reset rdata 16-bit", rd0, 32'h0);
        chk("R9 reset rdata 8-bit", rd1, 32'h0);
        chk("R9 reset strobes", {28'h0, s0_read, s0_write, s1_read, s1_write}, 32'h0);

        for (int st = 0; st < 2; st++) begin
            stall_en = (st != 0);
            for (int s = 0; s < 2; s++) begin
                for (int b = 0; b < 16; b++) begin
                    int a = (b * 3 + s + st * 5) % 64;
                    logic [31:0] wd;
                    logic [7:0] old [4];
                    // Read sweep.
                    do_access(s, a, 4'(b), 1'b0, 32'h0, rd, waits, start);
                    chk_cycles(s, a, 4'(b), start);
                    exp = '0;
                    for (int l = 0; l < 4; l++)
                        if (b[l]) exp[l*8 +: 8] = mbyte(s, a * 4 + l);
                    chk("R7 read assembly", rd, exp);
                    if (b == 0) chk("R10 empty read is zero", rd, 32'h0);
                    if (st == 0) chk("R8 wait length", waits, narrow_count(s, 4'(b)));
                    // Write sweep.
                    for (int l = 0; l < 4; l++) old[l] = mbyte(s, a * 4 + l);
                    wd = {8'(b + 8'h10), 8'(b * 5 + 1), 8'(~b), 8'(b + 8'hC0)};
                    do_access(s, a, 4'(b), 1'b1, wd, rd, waits, start);
                    chk_cycles(s, a, 4'(b), start);
                    for (int l = 0; l < 4; l++)
                        chk("R6 written byte", {24'h0, mbyte(s, a * 4 + l)},
                            {24'h0, b[l] ? wd[l*8 +: 8] : old[l]});
                    if (st == 0) chk("R8 write wait length", waits, narrow_count(s, 4'(b)));
                end
            end
        end

        // R9: reset in the middle of a split read on the 8-bit instance.
        stall_en = 1'b0;
        @(negedge clk);
        sel = 1'b1; m_addr = AW'(9); m_be = 4'hF; m_rd = 1'b1; m_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 strobe mid-access", {31'h0, s1_read}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-access reset strobes", {30'h0, s1_read, s1_write}, 32'h0);
        chk("R9 mid-access reset rdata", rd1, 32'h0);
        m_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // Block works again after reset.
        do_access(1, 9, 4'h2, 1'b0, 32'h0, rd, waits, start);
        chk_cycles(1, 9, 4'h2, start);
        chk("R7 read after reset", rd, {16'h0, mbyte(1, 37), 8'h0});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule